// File: doc/BRIEF.md
# Circular Instruction Extractor

This block sits between a per-wave line buffer and the wave's instruction queue. Completed cache lines are written into one of a fixed number of slots. Together the slots form a ring of bytes. A read pointer walks this ring. Each cycle the block may take one instruction from the pointer and push it into a small internal FIFO, which the issue logic drains. Each instruction is four or eight bytes long. The block always reads a full 64-bit raw word and reports whether the instruction uses both halves.

Extraction stops when fewer than eight valid bytes are ahead of the pointer, or when the FIFO is full. The count of valid bytes is measured from the pointer to the end of the most recently completed line. If that end lies behind the pointer, the valid region wraps around the ring, and the bytes held in all counted lines are added. When only the last 32-bit word of the ring is ahead of the pointer, the block builds the raw word from that last word and the first word of the ring, and then places the pointer just past the instruction's bytes at the ring start. A restart, used after a taken branch, empties the line count and places the pointer at a byte offset inside the first line.

Top module: `ext_insn_extract`

## Requirements
- R1: After reset the FIFO is empty (`ib_valid` low, `ib_count` 0), `rd_ptr` is 0 and `bytes_left` is 0.
- R2: `bytes_left` is 0 when no line is counted or when `rd_ptr` equals the ring size. Otherwise let E be (newest slot + 1) × line bytes. `bytes_left` is E − `rd_ptr` if E is larger, (line count × line bytes) + E − `rd_ptr` if E is smaller, and 0 if they are equal.
- R3: One instruction is pushed in a cycle exactly when `bytes_left` ≥ 8, the FIFO holds fewer than `IB_DEPTH` entries and no restart is requested. At most one instruction is pushed per cycle.
- R4: The low word of an instruction is the 32-bit word at `rd_ptr`. Word k of a line is `fill_data[32k+31:32k]`. The instruction is long (8 bytes, `ib_long` = 1) when bits 31:26 of the low word equal `LONG_OPC` (default 6'h3F). Otherwise it is short (4 bytes). `ib_raw` is {next word, low word}.
- R5: Without a wrap, a push advances `rd_ptr` by the instruction size (4 or 8).
- R6: When `rd_ptr` + 8 exceeds the ring size, bits 63:32 of the raw word come from ring word 0. After the push, `rd_ptr` equals the instruction size minus 4.
- R7: A line fill that arrives while `rd_ptr` equals the ring size sets `rd_ptr` to 0.
- R8: A restart sets the line count to 0 and `rd_ptr` to `restart_offset`, with priority over fills, releases and pushes.
- R9: The FIFO delivers instructions in ring order. `ib_pop` removes the head entry. `ib_count` gives the occupancy.
- R10: A fill raises the line count by one and makes its slot the newest. A release lowers the count by one. A fill and a release in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | A completed line is written this cycle |
| fill_slot | input | $clog2(NUM_LINES) | Slot receiving the line |
| fill_data | input | LINE_BYTES*8 | Line contents, word k in bits 32k+31:32k |
| release_valid | input | 1 | Oldest counted line is released |
| restart_valid | input | 1 | Flush the line count and reposition the pointer |
| restart_offset | input | $clog2(LINE_BYTES) | Byte offset for the pointer after a restart (multiple of 4) |
| ib_pop | input | 1 | Remove the FIFO head |
| ib_valid | output | 1 | FIFO head is valid |
| ib_raw | output | 64 | Raw instruction word at the head |
| ib_long | output | 1 | Head instruction is 8 bytes |
| ib_count | output | $clog2(IB_DEPTH+1) | FIFO occupancy |
| rd_ptr | output | $clog2(LINE_BYTES*NUM_LINES)+1 | Ring read pointer in bytes |
| bytes_left | output | $clog2(LINE_BYTES*NUM_LINES)+1 | Valid bytes ahead of the pointer |

## Verification
The split path is the hardest case to reach from the ports. It needs all slots filled, a pointer that lands on the final ring word through a chain of short instructions, a long instruction placed in that word, and a refill of slot 0 before extraction can continue. The bench fills the whole ring, drains fourteen instructions to bring the pointer to 60, and releases two lines so that the line count is visible in the wrapped `bytes_left` value. It then refills slots 0 and 1, which lets the split instruction and the wrapped read that follows proceed. A separate run ends a long instruction exactly at the ring end, so that the next fill wraps the pointer to 0.

// File: rtl/ext_pkg.sv
package ext_pkg;

    localparam int WORD_BITS  = 32;
    localparam int RAW_BYTES  = 8;
    localparam int HALF_BYTES = 4;
    localparam int OPC_HI     = 31;
    localparam int OPC_LO     = 26;

    typedef logic [WORD_BITS-1:0] word_t;

    typedef struct packed {
        logic [2*WORD_BITS-1:0] raw;
        logic                   is_long;
    } insn_t;

    typedef enum logic [1:0] {
        RD_HOLD,
        RD_RESTART,
        RD_STEP,
        RD_WRAP
    } rd_op_e;

    function automatic logic opc_is_long(word_t w, logic [5:0] opc);
        return w[OPC_HI:OPC_LO] == opc;
    endfunction

    function automatic int unsigned insn_bytes(logic is_long);
        return is_long ? RAW_BYTES : HALF_BYTES;
    endfunction

endpackage

// File: rtl/ext_linebuf.sv
module ext_linebuf
    import ext_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 4
)(
    input  logic                                               clk,
    input  logic                                               wr_en,
    input  logic [$clog2(NUM_LINES)-1:0]                       wr_slot,
    input  logic [LINE_BYTES*8-1:0]                            wr_data,
    input  logic [$clog2(LINE_BYTES*NUM_LINES/HALF_BYTES)-1:0] rd_idx,
    input  logic                                               wrap_hi,
    output word_t                                              lo_word,
    output word_t                                              hi_word
);

    localparam int WPL       = LINE_BYTES / HALF_BYTES;
    localparam int NUM_WORDS = WPL * NUM_LINES;
    localparam int WIDX_W    = $clog2(NUM_WORDS);

    word_t             mem [NUM_WORDS];
    logic [WIDX_W-1:0] hi_idx;

    // Whole line lands in one cycle; slot picks the word range.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < WPL; k++) begin
                mem[WIDX_W'(int'(wr_slot) * WPL + k)] <= wr_data[k*WORD_BITS +: WORD_BITS];
            end
        end
    end

    always_comb begin
        hi_idx  = wrap_hi ? '0 : rd_idx + 1'b1;
        lo_word = mem[rd_idx];
        hi_word = mem[hi_idx];
    end

endmodule

// File: rtl/ext_remain.sv
module ext_remain #(
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 4,
    parameter int PTR_W      = 7,
    parameter int CNT_W      = 3,
    parameter int SLOT_W     = 2
)(
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [CNT_W-1:0]  nlines,
    input  logic [SLOT_W-1:0] newest,
    output logic [PTR_W-1:0]  bytes_left
);

    localparam int BUF_BYTES = LINE_BYTES * NUM_LINES;

    int end_b;
    int tot_b;
    int rd_b;
    int res;

    always_comb begin
        end_b = (int'(newest) + 1) * LINE_BYTES;
        tot_b = int'(nlines) * LINE_BYTES;
        rd_b  = int'(rd_ptr);
        if (nlines == '0 || rd_b == BUF_BYTES) begin
            res = 0;
        end else if (end_b > rd_b) begin
            res = end_b - rd_b;
        end else if (end_b < rd_b) begin
            res = tot_b + end_b - rd_b;
        end else begin
            res = 0;
        end
        bytes_left = PTR_W'(res);
    end

endmodule

// File: rtl/ext_ibuf.sv
module ext_ibuf
    import ext_pkg::*;
#(
    parameter int DEPTH = 4
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  insn_t                      push_data,
    input  logic                       pop,
    output logic                       valid,
    output insn_t                      head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    insn_t         q [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic          push_ok;
    logic          pop_ok;

    always_comb begin
        full    = (count == CW'(DEPTH));
        valid   = (count != '0);
        push_ok = push && !full;
        pop_ok  = pop && valid;
        head    = q[rp];
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            q[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop_ok) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ext_insn_extract.sv
module ext_insn_extract
    import ext_pkg::*;
#(
    parameter int         LINE_BYTES = 16,
    parameter int         NUM_LINES  = 4,
    parameter int         IB_DEPTH   = 4,
    parameter logic [5:0] LONG_OPC   = 6'h3F
)(
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        fill_valid,
    input  logic [$clog2(NUM_LINES)-1:0]                fill_slot,
    input  logic [LINE_BYTES*8-1:0]                     fill_data,
    input  logic                                        release_valid,
    input  logic                                        restart_valid,
    input  logic [$clog2(LINE_BYTES)-1:0]               restart_offset,
    input  logic                                        ib_pop,
    output logic                                        ib_valid,
    output logic [63:0]                                 ib_raw,
    output logic                                        ib_long,
    output logic [$clog2(IB_DEPTH+1)-1:0]               ib_count,
    output logic [$clog2(LINE_BYTES*NUM_LINES):0]       rd_ptr,
    output logic [$clog2(LINE_BYTES*NUM_LINES):0]       bytes_left
);

    localparam int BUF_BYTES = LINE_BYTES * NUM_LINES;
    localparam int PTR_W     = $clog2(BUF_BYTES) + 1;
    localparam int SLOT_W    = $clog2(NUM_LINES);
    localparam int CNT_W     = $clog2(NUM_LINES + 1);
    localparam int WIDX_W    = $clog2(BUF_BYTES / HALF_BYTES);
    localparam logic [PTR_W-1:0] END_PTR = PTR_W'(BUF_BYTES);

    logic [PTR_W-1:0]  rd_q;
    logic [PTR_W-1:0]  rd_d;
    logic [CNT_W-1:0]  nlines_q;
    logic [SLOT_W-1:0] newest_q;
    word_t             lo_w;
    word_t             hi_w;
    logic              split;
    logic              take;
    logic              split_take;
    logic              is_long;
    logic              ib_full;
    rd_op_e            rd_op;
    insn_t             push_ins;
    insn_t             head_ins;

    ext_linebuf #(
        .LINE_BYTES (LINE_BYTES),
        .NUM_LINES  (NUM_LINES)
    ) u_linebuf (
        .clk     (clk),
        .wr_en   (fill_valid),
        .wr_slot (fill_slot),
        .wr_data (fill_data),
        .rd_idx  (rd_q[2 +: WIDX_W]),
        .wrap_hi (split),
        .lo_word (lo_w),
        .hi_word (hi_w)
    );

    ext_remain #(
        .LINE_BYTES (LINE_BYTES),
        .NUM_LINES  (NUM_LINES),
        .PTR_W      (PTR_W),
        .CNT_W      (CNT_W),
        .SLOT_W     (SLOT_W)
    ) u_remain (
        .rd_ptr     (rd_q),
        .nlines     (nlines_q),
        .newest     (newest_q),
        .bytes_left (bytes_left)
    );

    ext_ibuf #(
        .DEPTH (IB_DEPTH)
    ) u_ibuf (
        .clk       (clk),
        .rst       (rst),
        .push      (take),
        .push_data (push_ins),
        .pop       (ib_pop),
        .valid     (ib_valid),
        .head      (head_ins),
        .count     (ib_count),
        .full      (ib_full)
    );

    always_comb begin
        split      = ({1'b0, rd_q} + (PTR_W+1)'(RAW_BYTES)) > (PTR_W+1)'(BUF_BYTES);
        take       = !restart_valid && (bytes_left >= PTR_W'(RAW_BYTES)) && !ib_full;
        split_take = take && split;
        is_long    = opc_is_long(lo_w, LONG_OPC);
        push_ins   = '{raw: {hi_w, lo_w}, is_long: is_long};
        ib_raw     = head_ins.raw;
        ib_long    = head_ins.is_long;
        rd_ptr     = rd_q;
    end

    // Pointer update: restart wins, then a push, then a wrap on fill.
    always_comb begin
        if (restart_valid) begin
            rd_op = RD_RESTART;
        end else if (take) begin
            rd_op = RD_STEP;
        end else if (fill_valid && rd_q == END_PTR) begin
            rd_op = RD_WRAP;
        end else begin
            rd_op = RD_HOLD;
        end
        case (rd_op)
            RD_RESTART: rd_d = PTR_W'(restart_offset);
            RD_STEP:    rd_d = split ? PTR_W'(insn_bytes(is_long) - HALF_BYTES)
                                     : rd_q + PTR_W'(insn_bytes(is_long));
            RD_WRAP:    rd_d = '0;
            default:    rd_d = rd_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= '0;
            nlines_q <= '0;
            newest_q <= '0;
        end else begin
            rd_q <= rd_d;
            if (restart_valid) begin
                nlines_q <= '0;
            end else if (fill_valid && !release_valid) begin
                nlines_q <= nlines_q + 1'b1;
            end else if (!fill_valid && release_valid && nlines_q != '0) begin
                nlines_q <= nlines_q - 1'b1;
            end
            if (fill_valid && !restart_valid) begin
                newest_q <= fill_slot;
            end
        end
    end

endmodule

// File: rtl/ext_insn_extract_chk.sv
module ext_insn_extract_chk #(
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 4,
    parameter int IB_DEPTH   = 4
)(
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  fill_valid,
    input logic                                  restart_valid,
    input logic [$clog2(LINE_BYTES)-1:0]         restart_offset,
    input logic [$clog2(IB_DEPTH+1)-1:0]         ib_count,
    input logic [$clog2(LINE_BYTES*NUM_LINES):0] rd_ptr,
    input logic [$clog2(LINE_BYTES*NUM_LINES):0] bytes_left,
    input logic                                  split_take
);

    localparam int PTR_W = $clog2(LINE_BYTES * NUM_LINES) + 1;
    localparam logic [PTR_W-1:0] END_PTR = PTR_W'(LINE_BYTES * NUM_LINES);

    assert_ib_bound_R3: assert property (@(posedge clk) disable iff (rst)
        ib_count <= ($clog2(IB_DEPTH+1))'(IB_DEPTH));

    assert_no_push_when_short_R3: assert property (@(posedge clk) disable iff (rst)
        (bytes_left < PTR_W'(8)) |=> (ib_count <= $past(ib_count)));

    assert_rd_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr[1:0] == 2'b00) && (rd_ptr <= END_PTR));

    assert_split_lands_low_R6: assert property (@(posedge clk) disable iff (rst)
        (split_take && !restart_valid) |=> (rd_ptr <= PTR_W'(4)));

    assert_wrap_on_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !restart_valid && rd_ptr == END_PTR) |=> (rd_ptr == '0));

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        restart_valid |=> (bytes_left == '0 && rd_ptr == PTR_W'($past(restart_offset))));

    assert_end_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr == END_PTR) |-> (bytes_left == '0));

endmodule

bind ext_insn_extract ext_insn_extract_chk #(
    .LINE_BYTES (LINE_BYTES),
    .NUM_LINES  (NUM_LINES),
    .IB_DEPTH   (IB_DEPTH)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fill_valid     (fill_valid),
    .restart_valid  (restart_valid),
    .restart_offset (restart_offset),
    .ib_count       (ib_count),
    .rd_ptr         (rd_ptr),
    .bytes_left     (bytes_left),
    .split_take     (split_take)
);

// File: tb/ext_insn_extract_bench.sv
`timescale 1ns/1ps
module ext_insn_extract_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fill_valid = 1'b0;
    logic [1:0]   fill_slot = '0;
    logic [127:0] fill_data = '0;
    logic         release_valid = 1'b0;
    logic         restart_valid = 1'b0;
    logic [3:0]   restart_offset = '0;
    logic         ib_pop = 1'b0;
    logic         ib_valid;
    logic [63:0]  ib_raw;
    logic         ib_long;
    logic [2:0]   ib_count;
    logic [6:0]   rd_ptr;
    logic [6:0]   bytes_left;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [31:0] bw [16];
    logic [31:0] nb [8];

    ext_insn_extract u_ext_insn_extract (
        .clk            (clk),
        .rst            (rst),
        .fill_valid     (fill_valid),
        .fill_slot      (fill_slot),
        .fill_data      (fill_data),
        .release_valid  (release_valid),
        .restart_valid  (restart_valid),
        .restart_offset (restart_offset),
        .ib_pop         (ib_pop),
        .ib_valid       (ib_valid),
        .ib_raw         (ib_raw),
        .ib_long        (ib_long),
        .ib_count       (ib_count),
        .rd_ptr         (rd_ptr),
        .bytes_left     (bytes_left)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] sw(input int tag);
        return {6'h01, 26'(tag)};
    endfunction

    function automatic logic [31:0] lw(input int tag);
        return {6'h3F, 26'(tag)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int e_rd, input int e_left, input int e_cnt);
        chk(rd_ptr == 7'(e_rd), req, "rd_ptr", 64'(rd_ptr), 64'(e_rd));
        chk(bytes_left == 7'(e_left), req, "bytes_left", 64'(bytes_left), 64'(e_left));
        chk(ib_count == 3'(e_cnt), req, "ib_count", 64'(ib_count), 64'(e_cnt));
    endtask

    task automatic fill_line(input int slot, input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] c, input logic [31:0] d);
        fill_valid = 1'b1;
        fill_slot  = 2'(slot);
        fill_data  = {d, c, b, a};
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_restart(input int off);
        restart_valid  = 1'b1;
        restart_offset = 4'(off);
        @(negedge clk);
        restart_valid  = 1'b0;
    endtask

    task automatic do_release();
        release_valid = 1'b1;
        @(negedge clk);
        release_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [63:0] raw, input logic lng, input string req);
        int waited = 0;
        while (!ib_valid && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        chk(ib_valid, req, "ib_valid", 64'(ib_valid), 64'(1));
        chk(ib_raw == raw, req, "ib_raw", ib_raw, raw);
        chk(ib_long == lng, req, "ib_long", 64'(ib_long), 64'(lng));
        ib_pop = 1'b1;
        @(negedge clk);
        ib_pop = 1'b0;
    endtask

    task automatic fill_ring();
        for (int s = 0; s < 4; s++) begin
            fill_line(s, bw[4*s], bw[4*s+1], bw[4*s+2], bw[4*s+3]);
        end
    endtask

    // R1: reset values
    task automatic t_reset();
        chk(!ib_valid, "R1", "ib_valid", 64'(ib_valid), 64'(0));
        chk_state("R1", 0, 0, 0);
    endtask

    // R8, R2, R3, R4, R5: restart into the middle of a line
    task automatic t_offset();
        do_restart(8);
        chk_state("R8", 8, 0, 0);
        fill_line(0, sw(1), sw(2), sw(3), sw(4));
        chk_state("R2", 8, 8, 0);
        repeat (3) @(negedge clk);
        chk_state("R3", 12, 4, 1);
        pop_expect({sw(4), sw(3)}, 1'b0, "R4");
    endtask

    // R3, R5, R9, R10: FIFO bound then ordered drain
    task automatic t_bound();
        logic [31:0] v [8];
        for (int k = 0; k < 8; k++) v[k] = sw(10 + k);
        do_restart(0);
        fill_line(0, v[0], v[1], v[2], v[3]);
        fill_line(1, v[4], v[5], v[6], v[7]);
        repeat (8) @(negedge clk);
        chk_state("R3", 16, 16, 4);
        for (int k = 0; k < 7; k++) pop_expect({v[k+1], v[k]}, 1'b0, "R9");
        repeat (3) @(negedge clk);
        chk_state("R5", 28, 4, 0);
    endtask

    // R4, R6, R10, R2: long at ring end split across the wrap
    task automatic t_split();
        for (int k = 0; k < 16; k++) bw[k] = sw(20 + k);
        bw[0]  = lw(20);
        bw[15] = lw(35);
        for (int k = 0; k < 8; k++) nb[k] = sw(40 + k);
        do_restart(0);
        fill_ring();
        pop_expect({bw[1], bw[0]}, 1'b1, "R4");
        for (int k = 2; k < 15; k++) pop_expect({bw[k+1], bw[k]}, 1'b0, "R5");
        repeat (3) @(negedge clk);
        chk_state("R3", 60, 4, 0);
        do_release();
        do_release();
        chk_state("R2", 60, 4, 0);
        fill_line(0, nb[0], nb[1], nb[2], nb[3]);
        chk_state("R10", 60, 4, 0);
        fill_line(1, nb[4], nb[5], nb[6], nb[7]);
        chk_state("R2", 60, 36, 0);
        @(negedge clk);
        chk(rd_ptr == 7'd4, "R6", "rd_ptr after split", 64'(rd_ptr), 64'(4));
        pop_expect({nb[0], bw[15]}, 1'b1, "R6");
        for (int j = 1; j < 7; j++) pop_expect({nb[j+1], nb[j]}, 1'b0, "R9");
        repeat (3) @(negedge clk);
        chk_state("R2", 28, 4, 0);
    endtask

    // R5, R2, R7: long ending exactly at the ring end, then wrap on fill
    task automatic t_end_wrap();
        for (int k = 0; k < 16; k++) bw[k] = sw(50 + k);
        bw[14] = lw(64);
        do_restart(0);
        fill_ring();
        for (int k = 0; k < 14; k++) pop_expect({bw[k+1], bw[k]}, 1'b0, "R5");
        pop_expect({bw[15], bw[14]}, 1'b1, "R4");
        repeat (3) @(negedge clk);
        chk_state("R2", 64, 0, 0);
        do_release();
        fill_line(0, sw(70), sw(71), sw(72), sw(73));
        chk_state("R7", 0, 16, 0);
        pop_expect({sw(71), sw(70)}, 1'b0, "R7");
        pop_expect({sw(72), sw(71)}, 1'b0, "R9");
        pop_expect({sw(73), sw(72)}, 1'b0, "R9");
        repeat (3) @(negedge clk);
        chk_state("R5", 12, 4, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_offset();
        t_bound();
        t_split();
        t_end_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule